// File: doc/BRIEF.md
# Control-Status Register Unit with Host Message Channel

This block holds the small set of machine control and status registers that a simple in-order core needs: a free-running clock-cycle counter, a count of completed instructions, a fixed hardware thread number, and one write-only register whose writes are turned into messages for an external host. The core reads a register through a combinational port addressed by a 12-bit index. It writes through a second port, and every pulse on that port also marks one instruction as finished, whether or not a register index comes with it.

A write to the host register becomes a typed message: an exit code, a character to print, or the lower or upper half of an integer to print. The message carries 16 data bits. It is held on a valid/ready channel until the host takes it. While a message is waiting, the core must not post another one, so the unit drops its write-ready output. A separate start input lets the host hand the core its first program counter.

Top module: `sysreg_hostlink`

## Requirements
- R1: During reset the cycle and completion counters read 0, `msg_valid` and `boot_go` are 0, and `wr_rdy` is 1.
- R2: The cycle counter is 32 bits wide and increases by one on every clock after reset. Reading index `A_CYCLE` (default 0xC00) returns it.
- R3: Each accepted `wr_en` pulse adds one to the completion counter, whether `wr_idx_vld` is 0 or 1. Index `A_INSTRET` (default 0xC02) returns the count. A read in the same cycle as a pulse shows the value from before the pulse.
- R4: Reading index `A_HARTID` (default 0xF14) returns the `HART_ID` parameter, which defaults to 0.
- R5: Reading the host register index `A_TOHOST` (default 0x780), or any index the unit does not implement, returns 0.
- R6: A write to the cycle, completion or thread-number index leaves that register's value unchanged. It still counts as one completion.
- R7: An accepted write to `A_TOHOST` drives `msg_valid` high on the next clock. On that clock `msg_type` takes `wr_data[17:16]` (0 exit code, 1 print character, 2 print integer low half, 3 print integer high half) and `msg_data` takes `wr_data[15:0]`. All three hold until a clock where `msg_ready` is 1, and `msg_valid` falls on that clock.
- R8: While `msg_valid` is 1, `wr_rdy` is 0. A host-register write in such a cycle is not accepted: it adds no completion and does not change the message. Writes with no index, or to another index, are still accepted. This also holds in the cycle in which the host takes the message.
- R9: A clock with `start_valid` high loads `start_pc` into `boot_pc`. On the next clock `boot_go` is high for one cycle, and `boot_pc` then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Host supplies a start address |
| start_pc | input | 32 | Start address from host |
| boot_go | output | 1 | One-cycle pulse telling the core to begin |
| boot_pc | output | 32 | Captured start address |
| rd_idx | input | 12 | Read index |
| rd_data | output | 32 | Read value (combinational) |
| wr_en | input | 1 | Instruction-complete / write pulse |
| wr_idx_vld | input | 1 | A register index comes with the pulse |
| wr_idx | input | 12 | Write index |
| wr_data | input | 32 | Write value |
| wr_rdy | output | 1 | Low while a host-register write would stall |
| msg_valid | output | 1 | Host message pending |
| msg_ready | input | 1 | Host takes the message |
| msg_type | output | 2 | Message kind |
| msg_data | output | 16 | Message payload |

## Verification
Two of the unit's functions can fall in the same cycle in two ways. The host can take a pending message while the core posts the next host-register write. A completion pulse can also arrive while the core reads the completion counter. The bench drives `msg_ready` and a host-register write on the same clock. It expects the write to be refused: `msg_valid` low afterwards and the completion count unchanged. It also reads the completion index during a pulse and expects the value from before the pulse, then the value plus one.

// File: rtl/sysreg_hostlink.sv
module sysreg_hostlink #(
  parameter int XLEN  = 32,
  parameter int IDXW  = 12,
  parameter int MSGW  = 16,
  parameter int TYPEW = 2,
  parameter logic [XLEN-1:0] HART_ID   = '0,
  parameter logic [IDXW-1:0] A_CYCLE   = 12'hC00,
  parameter logic [IDXW-1:0] A_INSTRET = 12'hC02,
  parameter logic [IDXW-1:0] A_HARTID  = 12'hF14,
  parameter logic [IDXW-1:0] A_TOHOST  = 12'h780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic [XLEN-1:0]  start_pc,
  output logic             boot_go,
  output logic [XLEN-1:0]  boot_pc,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [XLEN-1:0]  rd_data,
  input  logic             wr_en,
  input  logic             wr_idx_vld,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  output logic             wr_rdy,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [TYPEW-1:0] msg_type,
  output logic [MSGW-1:0]  msg_data
);
  localparam int PAYW = MSGW + TYPEW;

  logic [XLEN-1:0] cyc_q, ret_q;
  logic host_hit, wr_take, unused_hi;

  assign host_hit  = wr_idx_vld && (wr_idx == A_TOHOST);
  assign wr_take   = wr_en && !(host_hit && msg_valid);
  assign wr_rdy    = !msg_valid;
  assign unused_hi = ^wr_data[XLEN-1:PAYW];

  always_comb begin
    case (rd_idx)
      A_CYCLE:   rd_data = cyc_q;
      A_INSTRET: rd_data = ret_q;
      A_HARTID:  rd_data = HART_ID;
      default:   rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q     <= '0;
      ret_q     <= '0;
      msg_valid <= 1'b0;
      msg_type  <= '0;
      msg_data  <= '0;
      boot_go   <= 1'b0;
      boot_pc   <= '0;
    end else begin
      cyc_q   <= cyc_q + 1'b1;
      boot_go <= start_valid;
      if (start_valid) boot_pc <= start_pc;
      if (wr_take) ret_q <= ret_q + 1'b1;
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (wr_take && host_hit) begin
        msg_valid <= 1'b1;
        msg_type  <= wr_data[PAYW-1:MSGW];
        msg_data  <= wr_data[MSGW-1:0];
      end
    end
  end

  // R2
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cyc_q == $past(cyc_q) + 1'b1);

  // R7
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_type) && $stable(msg_data));

  // R8
  stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && wr_en && host_hit |=> ret_q == $past(ret_q));

  // R5
  tohost_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx == A_TOHOST |-> rd_data == '0);

  // R9
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_go && !start_valid |=> !boot_go);
endmodule

// File: tb/sysreg_hostlink_tb.sv
module sysreg_hostlink_tb_top;
  localparam logic [11:0] IC = 12'hC00, II = 12'hC02, IH = 12'hF14, IT = 12'h780;
  localparam logic [31:0] HID = 32'd3;
  // {wr_data, expected type, expected data}
  localparam logic [49:0] VEC [4] = '{
    {32'h0000_0000, 2'd0, 16'h0000},
    {32'h0001_0041, 2'd1, 16'h0041},
    {32'hFFFE_BEEF, 2'd2, 16'hBEEF},
    {32'h0003_1234, 2'd3, 16'h1234}
  };

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, wr_en = 0, wr_idx_vld = 0, msg_ready = 0;
  logic [31:0] start_pc = '0, wr_data = '0;
  logic [11:0] rd_idx = '0, wr_idx = '0;
  logic boot_go, wr_rdy, msg_valid;
  logic [31:0] boot_pc, rd_data;
  logic [1:0] msg_type;
  logic [15:0] msg_data;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_ret = 0, tmp;
  bit done = 0;

  always #5 clk = ~clk;

  sysreg_hostlink #(.HART_ID(HID)) dut_i (
    .clk, .rst_n, .start_valid, .start_pc, .boot_go, .boot_pc,
    .rd_idx, .rd_data, .wr_en, .wr_idx_vld, .wr_idx, .wr_data, .wr_rdy,
    .msg_valid, .msg_ready, .msg_type, .msg_data);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [11:0] idx, output logic [31:0] v);
    rd_idx = idx; #1; v = rd_data;
  endtask

  task automatic pulse(input logic vld, input logic [11:0] idx, input logic [31:0] d);
    wr_en = 1; wr_idx_vld = vld; wr_idx = idx; wr_data = d;
    tick;
    wr_en = 0; wr_idx_vld = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) tick;
    // R1 reset state
    rd(IC, v); chk("R1 cycle", v, 0);
    rd(II, v); chk("R1 instret", v, 0);
    chk("R1 msg_valid", {31'd0, msg_valid}, 0);
    chk("R1 wr_rdy", {31'd0, wr_rdy}, 1);
    chk("R1 boot_go", {31'd0, boot_go}, 0);
    rst_n = 1;

    // R2 cycle counter steps
    rd(IC, v); tick; rd(IC, v2); chk("R2 step", v2, v + 1);
    repeat (5) tick; rd(IC, v); chk("R2 five", v, v2 + 5);

    // R4 / R5 reads
    rd(IH, v); chk("R4 hartid", v, HID);
    rd(IT, v); chk("R5 tohost", v, 0);
    rd(12'h123, v); chk("R5 unimpl", v, 0);

    // R7 vector table walk
    foreach (VEC[i]) begin
      pulse(1, IT, VEC[i][49:18]); exp_ret++;
      chk("R7 valid", {31'd0, msg_valid}, 1);
      chk("R7 type", {30'd0, msg_type}, {30'd0, VEC[i][17:16]});
      chk("R7 data", {16'd0, msg_data}, {16'd0, VEC[i][15:0]});
      chk("R8 rdy low", {31'd0, wr_rdy}, 0);
      tick;
      chk("R7 hold", {31'd0, msg_valid}, 1);
      msg_ready = 1; tick; msg_ready = 0;
      chk("R7 drop", {31'd0, msg_valid}, 0);
    end
    rd(II, v); chk("R3 count after table", v, exp_ret);

    // R3 no-index completion and same-cycle read
    rd_idx = II; wr_en = 1; wr_idx_vld = 0; #1;
    chk("R3 same-cycle old", rd_data, exp_ret);
    tick; wr_en = 0; exp_ret++;
    rd(II, v); chk("R3 no-index pulse", v, exp_ret);

    // R6 writes to read-only registers
    rd(IC, v); pulse(1, IC, 32'hFFFF_0000); exp_ret++;
    rd(IC, v2); chk("R6 cycle", v2, v + 1);
    pulse(1, II, 32'h0000_1234); exp_ret++;
    rd(II, v); chk("R6 instret", v, exp_ret);
    pulse(1, IH, 32'hAAAA_5555); exp_ret++;
    rd(IH, v); chk("R6 hartid", v, HID);

    // R8 stall while pending
    pulse(1, IT, 32'h0001_0058); exp_ret++;
    pulse(1, IT, 32'h0002_7777);
    chk("R8 msg kept", {16'd0, msg_data}, 32'h0058);
    rd(II, v); chk("R8 no count", v, exp_ret);
    pulse(0, 12'h0, 32'h0); exp_ret++;
    rd(II, v); chk("R8 other accepted", v, exp_ret);
    // R8 collision: host takes message in same cycle as new host write
    msg_ready = 1; pulse(1, IT, 32'h0003_9999); msg_ready = 0;
    chk("R8 collide valid", {31'd0, msg_valid}, 0);
    rd(II, v); chk("R8 collide count", v, exp_ret);
    chk("R8 rdy back", {31'd0, wr_rdy}, 1);

    // R9 start
    start_valid = 1; start_pc = 32'h8000_0000; tick; start_valid = 0; start_pc = 0;
    chk("R9 go", {31'd0, boot_go}, 1);
    chk("R9 pc", boot_pc, 32'h8000_0000);
    tick;
    chk("R9 pulse end", {31'd0, boot_go}, 0);
    chk("R9 pc held", boot_pc, 32'h8000_0000);

    tmp = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule